// File: doc/BRIEF.md
# Edge/Level Interrupt Pin Detector

This block watches one active-low external interrupt pin and turns it into a request for the core's interrupt arbiter. The pin is first brought into the core clock domain through a chain of flops. A mode input then picks between two detection styles. In edge mode a falling edge is captured and held pending until the arbiter acknowledges it. In level mode nothing is stored: the request is live only while the synchronized pin is low during a pipeline-advance strobe, which marks the fetch-to-decode transition.

Edge capture runs as a two-state machine. `ST_IDLE` moves to `ST_PEND` on the transition *capture*, which is a high-to-low change of the synchronized sample. `ST_PEND` returns to `ST_IDLE` on the transition *release*, which is an acknowledge with no new edge in that cycle. `ST_PEND` stays where it is on *rearm*, an acknowledge that coincides with a new edge, and on *hold*, when no acknowledge arrives. Either state drops to `ST_IDLE` on *flush* while level mode is selected. An instance built with `IS_NMI` set ignores the mode input and always uses edge capture, which suits a nonmaskable pin.

Top module: `irq_pin_detect`

## Requirements
- R1: In edge mode, `req` rises after the third rising clock edge that follows the pin going low. Only a high-to-low change of the synchronized pin sets it.
- R2: In edge mode, a captured request stays asserted through any pattern of `advance` until it is acknowledged.
- R3: In edge mode, `ack` with no new edge clears `req` after the next clock edge. A pin that is still held low does not set it again.
- R4: In edge mode, if `ack` arrives in the same cycle as a new synchronized falling edge, `req` stays asserted.
- R5: In level mode (`mode_level`=1), `req` is high in exactly the cycles where `advance` is high and the synchronized pin is low. It follows combinationally within the cycle, and `ack` has no effect.
- R6: In level mode, a low that lasts only while `advance` is low is missed. A low held across two advance cycles produces a request in each of them.
- R7: Selecting level mode discards a latched edge request. Returning to edge mode does not restore it.
- R8: With `IS_NMI`=1, `mode_level` is ignored and the pin is always detected by falling edge with latching.
- R9: During and after reset, `req` is low and the synchronizer holds the idle-high value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pin_n | input | 1 | External active-low interrupt pin (asynchronous) |
| mode_level | input | 1 | 1 = level detection, 0 = edge detection |
| advance | input | 1 | Fetch-to-decode pipeline-advance strobe |
| ack | input | 1 | Acknowledge from the arbiter |
| req | output | 1 | Interrupt request to the arbiter |

## Verification
Edge mode is driven with a fall that is then held low, a fall followed by an acknowledge while the pin stays low, and a fresh fall timed to meet an acknowledge. Together these separate latching from re-triggering and from losing an edge. Level mode is driven with a low that spans advance strobes and a low that falls entirely inside a halt. This shows that the level path has no memory and can fire more than once. A switch of mode in the middle of a pending request, and a nonmaskable instance fed a level-mode select, confirm that a latched request is discarded and that the fixed variant ignores the mode input.

// File: rtl/irq_det_pkg.sv
package irq_det_pkg;
    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_PEND = 1'b1
    } edge_st_e;
endpackage

// File: rtl/irq_pin_sync.sv
module irq_pin_sync #(
    parameter int   STAGES  = 2,
    parameter logic RST_VAL = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] chain;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain <= {STAGES{RST_VAL}};
        else        chain <= {chain[STAGES-2:0], d};
    end

    assign q = chain[STAGES-1];
endmodule

// File: rtl/irq_edge_fsm.sv
module irq_edge_fsm
    import irq_det_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic s_pin,   // synchronized pin, active low
    input  logic flush,
    input  logic ack,
    output logic pend
);
    edge_st_e state, state_nx;
    logic     prev;
    logic     fall;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev <= 1'b1;
        else        prev <= s_pin;
    end

    assign fall = prev & ~s_pin;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    // next-state: capture, release, rearm, hold, flush
    always_comb begin
        state_nx = state;
        if (flush) begin
            state_nx = ST_IDLE;
        end else begin
            unique case (state)
                ST_IDLE: if (fall)        state_nx = ST_PEND;
                ST_PEND: if (ack && !fall) state_nx = ST_IDLE;
                default:                  state_nx = ST_IDLE;
            endcase
        end
    end

    // outputs
    always_comb begin
        unique case (state)
            ST_PEND: pend = 1'b1;
            default: pend = 1'b0;
        endcase
    end

    // R1 / R4: a synchronized fall always leaves the request pending
    p_fall_sets_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (fall && !flush) |=> pend);
    // R2: pending holds until acknowledged
    p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (pend && !ack && !flush) |=> pend);
    // R3: acknowledge without a new edge releases
    p_release_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (pend && ack && !fall && !flush) |=> !pend);
endmodule

// File: rtl/irq_pin_detect.sv
module irq_pin_detect #(
    parameter int SYNC_STAGES = 2,
    parameter bit IS_NMI      = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin_n,
    input  logic mode_level,
    input  logic advance,
    input  logic ack,
    output logic req
);
    logic s_pin;
    logic mode_eff;
    logic edge_pend;

    generate
        if (IS_NMI) begin : g_fixed
            assign mode_eff = 1'b0;
        end else begin : g_select
            assign mode_eff = mode_level;
        end
    endgenerate

    irq_pin_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (pin_n),
        .q     (s_pin)
    );

    irq_edge_fsm u_edge (
        .clk   (clk),
        .rst_n (rst_n),
        .s_pin (s_pin),
        .flush (mode_eff),
        .ack   (ack),
        .pend  (edge_pend)
    );

    assign req = mode_eff ? (advance & ~s_pin) : edge_pend;

    // R5: level mode never requests outside an advance
    p_level_gate_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_eff && !advance) |-> !req);
    // R7: level mode discards any latched edge request
    p_level_clears_r7: assert property (@(posedge clk) disable iff (!rst_n)
        mode_eff |=> !edge_pend);
endmodule

// File: tb/irq_pin_detect_tb_top.sv
`timescale 1ns/1ps
module irq_pin_detect_tb_top;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic pin_n = 1'b1;
    logic mode_level = 1'b0;
    logic advance = 1'b0;
    logic ack = 1'b0;
    logic req, nmi_req;
    int   n_chk = 0;
    int   n_bad = 0;
    bit   done = 1'b0;

    always #2 clk = ~clk;   // 250 MHz

    irq_pin_detect #(.SYNC_STAGES(2), .IS_NMI(1'b0)) dut_i (
        .clk(clk), .rst_n(rst_n), .pin_n(pin_n), .mode_level(mode_level),
        .advance(advance), .ack(ack), .req(req));

    irq_pin_detect #(.SYNC_STAGES(2), .IS_NMI(1'b1)) nmi_i (
        .clk(clk), .rst_n(rst_n), .pin_n(pin_n), .mode_level(mode_level),
        .advance(advance), .ack(ack), .req(nmi_req));

    task automatic tick(int n = 1);
        for (int i = 0; i < n; i++) begin
            @(posedge clk);
            @(negedge clk);
        end
    endtask

    task automatic check(logic got, logic exp, string tag);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: got %b expected %b", tag, got, exp);
        end
    endtask

    task automatic t_reset_r9();
        check(req, 1'b0, "R9 req low in reset");
        tick(2);
        rst_n = 1'b1;
        tick(3);
        check(req, 1'b0, "R9 req low after reset with idle pin");
    endtask

    task automatic t_edge_capture_r1_r2_r3();
        mode_level = 1'b0;
        pin_n = 1'b0;
        tick(2);
        check(req, 1'b0, "R1 not yet after two edges");
        tick(1);
        check(req, 1'b1, "R1 set after third edge");
        for (int i = 0; i < 4; i++) begin
            advance = i[0];
            tick(1);
            check(req, 1'b1, "R2 stays latched over advance pattern");
        end
        advance = 1'b0;
        ack = 1'b1;
        tick(1);
        ack = 1'b0;
        check(req, 1'b0, "R3 ack clears");
        tick(3);
        check(req, 1'b0, "R3 held-low pin does not retrigger");
    endtask

    task automatic t_ack_collision_r4();
        pin_n = 1'b1;
        tick(4);
        pin_n = 1'b0;
        tick(3);
        check(req, 1'b1, "R4 precondition pending");
        pin_n = 1'b1;
        tick(4);
        pin_n = 1'b0;
        tick(2);          // synchronized fall now visible
        ack = 1'b1;
        tick(1);
        ack = 1'b0;
        check(req, 1'b1, "R4 coincident fall keeps request");
        ack = 1'b1;
        tick(1);
        ack = 1'b0;
        check(req, 1'b0, "R3 plain ack clears after rearm");
    endtask

    task automatic t_level_r5_r6();
        pin_n = 1'b1;
        tick(3);
        mode_level = 1'b1;
        pin_n = 1'b0;
        tick(2);
        check(req, 1'b0, "R5 no request without advance");
        advance = 1'b1;
        #1;
        check(req, 1'b1, "R5 request with advance and low pin");
        ack = 1'b1;
        #0.5;
        check(req, 1'b1, "R5 ack has no effect in level mode");
        ack = 1'b0;
        tick(1);
        check(req, 1'b1, "R6 second advance while low fires again");
        advance = 1'b0;
        #1;
        check(req, 1'b0, "R5 drops with advance");
        pin_n = 1'b1;
        tick(3);
        pin_n = 1'b0;
        tick(3);
        check(req, 1'b0, "R6 low during halt gives nothing");
        pin_n = 1'b1;
        tick(3);
        advance = 1'b1;
        #1;
        check(req, 1'b0, "R6 halted low is not remembered");
        advance = 1'b0;
        tick(1);
    endtask

    task automatic t_mode_switch_r7();
        mode_level = 1'b0;
        pin_n = 1'b1;
        tick(3);
        pin_n = 1'b0;
        tick(3);
        check(req, 1'b1, "R7 precondition pending");
        mode_level = 1'b1;
        tick(1);
        mode_level = 1'b0;
        #1;
        check(req, 1'b0, "R7 edge request gone on return");
        tick(2);
        check(req, 1'b0, "R7 request not restored");
    endtask

    task automatic t_nmi_r8();
        pin_n = 1'b1;
        mode_level = 1'b1;
        tick(3);
        ack = 1'b1;
        tick(1);
        ack = 1'b0;
        check(nmi_req, 1'b0, "R8 nmi idle");
        pin_n = 1'b0;
        tick(3);
        check(nmi_req, 1'b1, "R8 nmi latches edge despite level select");
        tick(2);
        check(nmi_req, 1'b1, "R8 nmi stays pending without advance");
    endtask

    initial begin
        @(negedge clk);
        t_reset_r9();
        t_edge_capture_r1_r2_r3();
        t_ack_collision_r4();
        t_level_r5_r6();
        t_mode_switch_r7();
        t_nmi_r8();
        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        #400000;
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end
endmodule